// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines, picks the most urgent one with a fixed priority order, and raises a single interrupt line towards a processor. The processor answers with a two-pulse, active-low acknowledge strobe. The first pulse moves the winning request into the in-service set. During the second pulse the block presents an 8-bit vector, made of a 5-bit programmed base and the 3-bit line number. A one-cycle end-of-interrupt strobe later retires the most urgent in-service entry.

Several instances can be chained so that they share one acknowledge sequence. A controller strapped as master marks, in a slave-present mask, the request lines that have a downstream controller attached. When such a line wins, the master puts the line number on a 3-bit cascade bus and does not drive the vector itself. A controller strapped as slave compares the cascade bus with its own programmed address on the first acknowledge pulse. Only on a match does it take the request into service and later supply the vector. A slave's interrupt output is meant to feed one request input of the master.

All inputs are sampled on the rising clock edge. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `cascade_pic`

## Requirements
- R1: A 0-to-1 change on a request line, first seen at clock edge N, latches that line as pending at edge N. If nothing blocks it, `irq_o` is high after edge N+1. A line held high latches nothing further.
- R2: Among pending unmasked lines, the lowest index wins. The vector is `{vec_base_i[4:0], line[2:0]}`, with the line number in bits 2:0.
- R3: A line whose `mask_i` bit is 1 takes no part in resolution, but its latched request stays pending. Once the mask bit clears, it raises `irq_o` at the next edge.
- R4: The winner raises `irq_o` only if its index is strictly lower than that of every in-service line.
- R5: At the edge that samples the first falling edge of `inta_n_i` (a falling edge while no acknowledge is in progress), `irq_o` goes low. If the controller is selected, the winner leaves the pending set and enters the in-service set at that same edge. `irq_o` stays low until the edge that samples `inta_n_i` high after the second pulse, and at that edge it is evaluated again.
- R6: At the edge that samples the second falling edge, a selected controller sets `vec_oe_o` with the vector. It clears `vec_oe_o` at the edge that samples `inta_n_i` high again.
- R7: In master mode, `cas_oe_o` is high and `cas_o` carries the winning line number whenever `irq_o` is high and the winner's `slave_mask_i` bit is 1. Both hold through the acknowledge sequence, and the master keeps `vec_oe_o` low. In slave mode `cas_oe_o` is always low.
- R8: A slave is selected only if `cas_i` equals `own_addr_i` when the first falling edge is sampled. An unselected slave keeps its pending and in-service sets unchanged and drives no vector, so `irq_o` returns high at the completion edge.
- R9: A one-cycle `eoi_i` clears only the lowest-index in-service bit. `irq_o` reflects the change one edge later.
- R10: While reset is applied, `irq_o`, `vec_oe_o` and `cas_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Interrupt request lines, edge sensitive |
| mask_i | input | 8 | 1 excludes a line from resolution |
| is_master_i | input | 1 | 1 = cascade master, 0 = cascade slave |
| slave_mask_i | input | 8 | Master: lines with a slave attached |
| own_addr_i | input | 3 | Slave: own cascade address |
| vec_base_i | input | 5 | Upper five vector bits |
| inta_n_i | input | 1 | Active-low acknowledge strobe, two pulses |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| cas_i | input | 3 | Cascade bus as seen by a slave |
| cas_o | output | 3 | Cascade bus driven by a master |
| cas_oe_o | output | 1 | Enable for `cas_o` |
| irq_o | output | 1 | Interrupt request output |
| vec_o | output | 8 | Interrupt vector |
| vec_oe_o | output | 1 | Enable for `vec_o` |

## Verification
Every result is registered, so the bench applies each stimulus half a period before a rising edge and expects its effect just after that edge or the next one. A new request latches at the first edge and `irq_o` follows one edge later. An acknowledge edge or its completion acts at the edge that samples it. An end-of-interrupt clears the in-service bit at once, but `irq_o` only shows it one edge later. The driver queues exactly one expected output set for each edge, and the monitor pops one set one time unit after each edge. Any added or missing register stage therefore shows up as a mismatch on a named requirement.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDXW  = $clog2(LINES);
  localparam int unsigned BASEW = 8 - IDXW;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_SECOND = 2'd2
  } ack_state_e;

  // index of the lowest set bit (0 when none set)
  function automatic logic [IDXW-1:0] lowest_set(input logic [LINES-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver
  import pic_pkg::*;
(
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] insvc_i,
  input  logic [LINES-1:0] mask_i,
  output logic [IDXW-1:0]  win_idx_o,
  output logic             grant_o,
  output logic [LINES-1:0] insvc_low_oh_o
);
  logic [LINES-1:0] cand;
  logic             cand_any;
  logic             insvc_any;
  logic [IDXW-1:0]  insvc_idx;

  always_comb begin
    cand      = pend_i & ~mask_i;
    cand_any  = |cand;
    win_idx_o = lowest_set(cand);
    insvc_any = |insvc_i;
    insvc_idx = lowest_set(insvc_i);
    grant_o   = cand_any && (!insvc_any || (win_idx_o < insvc_idx));
    insvc_low_oh_o = insvc_i & ~(insvc_i - LINES'(1));
  end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inta_n_i,
  input  logic             is_master_i,
  input  logic [IDXW-1:0]  own_addr_i,
  input  logic [IDXW-1:0]  cas_i,
  input  logic [LINES-1:0] slave_mask_i,
  input  logic [BASEW-1:0] vec_base_i,
  input  logic             irq_i,
  input  logic [IDXW-1:0]  win_idx_i,
  output logic             take_o,
  output logic             active_next_o,
  output logic [IDXW-1:0]  cas_o,
  output logic             cas_oe_o,
  output logic [7:0]       vec_o,
  output logic             vec_oe_o
);
  ack_state_e      state_q, state_n;
  logic            inta_q;
  logic            sel_q, sel_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic            cas_oe_q, cas_oe_n;
  logic            vec_oe_q, vec_oe_n;
  logic [7:0]      vec_q, vec_n;
  logic            fall, hit;

  always_comb begin
    fall     = inta_q && !inta_n_i;
    hit      = irq_i && (is_master_i || (cas_i == own_addr_i));
    state_n  = state_q;
    sel_n    = sel_q;
    idx_n    = idx_q;
    cas_oe_n = cas_oe_q;
    vec_oe_n = vec_oe_q;
    vec_n    = vec_q;
    take_o   = 1'b0;
    unique case (state_q)
      ACK_IDLE: if (fall) begin
        state_n  = ACK_FIRST;
        sel_n    = hit;
        idx_n    = win_idx_i;
        take_o   = hit;
        cas_oe_n = hit && is_master_i && slave_mask_i[win_idx_i];
      end
      ACK_FIRST: if (fall) begin
        state_n  = ACK_SECOND;
        vec_oe_n = sel_q && !(is_master_i && slave_mask_i[idx_q]);
        vec_n    = {vec_base_i, idx_q};
      end
      ACK_SECOND: if (inta_n_i) begin
        state_n  = ACK_IDLE;
        vec_oe_n = 1'b0;
        cas_oe_n = 1'b0;
        sel_n    = 1'b0;
      end
      default: state_n = ACK_IDLE;
    endcase
    active_next_o = (state_n != ACK_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ACK_IDLE;
      inta_q   <= 1'b1;
      sel_q    <= 1'b0;
      idx_q    <= '0;
      cas_oe_q <= 1'b0;
      vec_oe_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      state_q  <= state_n;
      inta_q   <= inta_n_i;
      sel_q    <= sel_n;
      idx_q    <= idx_n;
      cas_oe_q <= cas_oe_n;
      vec_oe_q <= vec_oe_n;
      vec_q    <= vec_n;
    end
  end

  always_comb begin
    if (state_q == ACK_IDLE) begin
      cas_o    = win_idx_i;
      cas_oe_o = is_master_i && irq_i && slave_mask_i[win_idx_i];
    end else begin
      cas_o    = idx_q;
      cas_oe_o = cas_oe_q;
    end
    vec_o    = vec_q;
    vec_oe_o = vec_oe_q;
  end

  // R6
  vec_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_oe_q) |-> !$past(inta_n_i));

  // R7
  master_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master_i && cas_oe_o) |-> !vec_oe_o);

  // R7
  slave_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master_i |-> !cas_oe_o);
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] mask_i,
  input  logic             is_master_i,
  input  logic [LINES-1:0] slave_mask_i,
  input  logic [IDXW-1:0]  own_addr_i,
  input  logic [BASEW-1:0] vec_base_i,
  input  logic             inta_n_i,
  input  logic             eoi_i,
  input  logic [IDXW-1:0]  cas_i,
  output logic [IDXW-1:0]  cas_o,
  output logic             cas_oe_o,
  output logic             irq_o,
  output logic [7:0]       vec_o,
  output logic             vec_oe_o
);
  logic             rst_meta, rst_s_n;
  logic [LINES-1:0] req_q, rise;
  logic [LINES-1:0] pend_q, pend_n;
  logic [LINES-1:0] insvc_q, insvc_n;
  logic             irq_q, irq_n;
  logic [IDXW-1:0]  win_idx;
  logic             grant;
  logic [LINES-1:0] insvc_low_oh;
  logic [LINES-1:0] take_oh;
  logic             take, active_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  pic_prio_resolver u_res (
    .pend_i         (pend_q),
    .insvc_i        (insvc_q),
    .mask_i         (mask_i),
    .win_idx_o      (win_idx),
    .grant_o        (grant),
    .insvc_low_oh_o (insvc_low_oh)
  );

  pic_ack_seq u_ack (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .inta_n_i      (inta_n_i),
    .is_master_i   (is_master_i),
    .own_addr_i    (own_addr_i),
    .cas_i         (cas_i),
    .slave_mask_i  (slave_mask_i),
    .vec_base_i    (vec_base_i),
    .irq_i         (irq_q),
    .win_idx_i     (win_idx),
    .take_o        (take),
    .active_next_o (active_next),
    .cas_o         (cas_o),
    .cas_oe_o      (cas_oe_o),
    .vec_o         (vec_o),
    .vec_oe_o      (vec_oe_o)
  );

  always_comb begin
    rise    = req_i & ~req_q;
    take_oh = take ? (LINES'(1) << win_idx) : '0;
    pend_n  = (pend_q | rise) & ~take_oh;
    insvc_n = (insvc_q & ~(eoi_i ? insvc_low_oh : '0)) | take_oh;
    irq_n   = active_next ? 1'b0 : grant;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      insvc_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      req_q   <= req_i;
      pend_q  <= pend_n;
      insvc_q <= insvc_n;
      irq_q   <= irq_n;
    end
  end

  assign irq_o = irq_q;

  // R5
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    take |=> !irq_o);

  // R5
  insvc_grow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($countones(insvc_q) > $countones($past(insvc_q))) |-> $past(take));

  // R9
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eoi_i && !take && (insvc_q != '0)) |=>
      ($countones(insvc_q) + 1 == $countones($past(insvc_q))));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_s_n |-> (!irq_o && !vec_oe_o));
endmodule

// File: tb/sim_cascade_pic.sv
module sim_cascade_pic;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req, mask, smask;
  logic       is_master, inta_n, eoi;
  logic [2:0] own_addr, cas_in;
  logic [4:0] base;
  logic [2:0] cas_o;
  logic       cas_oe, irq, vec_oe;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    bit         irq;
    bit         voe;
    logic [7:0] vec;
    bit         coe;
    logic [2:0] cas;
  } exp_t;

  exp_t scb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cascade_pic u0 (
    .clk (clk), .rst_n (rst_n), .req_i (req), .mask_i (mask),
    .is_master_i (is_master), .slave_mask_i (smask), .own_addr_i (own_addr),
    .vec_base_i (base), .inta_n_i (inta_n), .eoi_i (eoi), .cas_i (cas_in),
    .cas_o (cas_o), .cas_oe_o (cas_oe), .irq_o (irq), .vec_o (vec),
    .vec_oe_o (vec_oe)
  );

  function automatic void push(string tag, bit i, bit voe, logic [7:0] v,
                               bit coe, logic [2:0] c);
    exp_t e;
    e.tag = tag; e.irq = i; e.voe = voe; e.vec = v; e.coe = coe; e.cas = c;
    scb.push_back(e);
  endfunction

  function automatic void cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  // monitor: one expected set per rising edge, sampled 1 time unit later
  always @(posedge clk) begin
    #1;
    cycles++;
    if (scb.size() != 0) begin
      exp_t e;
      e = scb.pop_front();
      cmp(e.tag, "irq_o", int'(irq), int'(e.irq));
      cmp(e.tag, "vec_oe_o", int'(vec_oe), int'(e.voe));
      if (e.voe) cmp(e.tag, "vec_o", int'(vec), int'(e.vec));
      cmp(e.tag, "cas_oe_o", int'(cas_oe), int'(e.coe));
      if (e.coe) cmp(e.tag, "cas_o", int'(cas_o), int'(e.cas));
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(string tag, bit i, bit coe = 0, logic [2:0] c = 0);
    @(negedge clk);
    push(tag, i, 0, 8'h00, coe, c);
  endtask

  task automatic raise(string tag, int line, bit i, bit coe = 0, logic [2:0] c = 0);
    @(negedge clk);
    req[line] = 1'b1;
    push(tag, i, 0, 8'h00, coe, c);
  endtask

  task automatic eoi_pulse(string tag, bit i_now, bit i_next);
    @(negedge clk);
    eoi = 1'b1;
    push(tag, i_now, 0, 8'h00, 0, 0);
    @(negedge clk);
    eoi = 1'b0;
    push(tag, i_next, 0, 8'h00, 0, 0);
  endtask

  task automatic ack(string tag, bit voe, logic [7:0] v, bit coe, logic [2:0] c,
                     bit irq_after);
    @(negedge clk); inta_n = 1'b0; push(tag, 0, 0, 8'h00, coe, c);
    @(negedge clk); inta_n = 1'b1; push(tag, 0, 0, 8'h00, coe, c);
    @(negedge clk); inta_n = 1'b0; push(tag, 0, voe, v, coe, c);
    @(negedge clk); inta_n = 1'b1; push(tag, irq_after, 0, 8'h00, 0, 0);
  endtask

  task automatic do_reset(bit master);
    @(negedge clk);
    rst_n = 1'b0; is_master = master;
    req = '0; mask = '0; inta_n = 1'b1; eoi = 1'b0;
    push("R10 reset", 0, 0, 8'h00, 0, 0);
    @(negedge clk); push("R10 reset", 0, 0, 8'h00, 0, 0);
    rst_n = 1'b1;
    repeat (3) idle("R10 after reset", 0);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; mask = '0; smask = 8'h80; is_master = 1'b1;
    inta_n = 1'b1; eoi = 1'b0; own_addr = 3'd5; cas_in = 3'd0; base = 5'b10101;

    // ---------------- master mode ----------------
    do_reset(1'b1);
    raise("R1 latch", 2, 0);
    idle("R1 irq next edge", 1);
    ack("R6 vector line2", 1, 8'hAA, 0, 0, 0);

    // R4: two requests blocked by in-service line 2
    @(negedge clk); req[5] = 1'b1; req[3] = 1'b1; push("R4 blocked", 0, 0, 0, 0, 0);
    idle("R4 blocked", 0);
    eoi_pulse("R9 release line2", 0, 1);
    ack("R2 lowest wins", 1, 8'hAB, 0, 0, 0);      // R5 irq stays low after
    raise("R4 nest higher", 1, 0);
    idle("R4 nest higher", 1);
    ack("R2 vector line1", 1, 8'hA9, 0, 0, 0);
    eoi_pulse("R9 clears only line1", 0, 0);       // line3 still blocks line5
    eoi_pulse("R9 clears line3", 0, 1);
    ack("R2 vector line5", 1, 8'hAD, 0, 0, 0);
    eoi_pulse("R9 clear line5", 0, 0);

    // R3 masking
    @(negedge clk); mask = 8'h01; req[0] = 1'b1; push("R3 masked", 0, 0, 0, 0, 0);
    idle("R3 masked", 0);
    idle("R3 masked", 0);
    @(negedge clk); mask = 8'h00; push("R3 unmasked", 1, 0, 0, 0, 0);
    ack("R3 vector line0", 1, 8'hA8, 0, 0, 0);
    eoi_pulse("R9 clear line0", 0, 0);

    // R7 cascade master, slave on line 7
    raise("R7 slave line", 7, 0);
    idle("R7 cas before ack", 1, 1, 3'd7);
    ack("R7 master silent", 0, 8'h00, 1, 3'd7, 0);
    eoi_pulse("R9 clear line7", 0, 0);

    // ---------------- slave mode ----------------
    do_reset(1'b0);
    own_addr = 3'd5; cas_in = 3'd2;
    raise("R1 slave latch", 6, 0);
    idle("R1 slave irq", 1);
    ack("R8 address mismatch", 0, 8'h00, 0, 0, 1);
    @(negedge clk); cas_in = 3'd5; push("R8 still pending", 1, 0, 0, 0, 0);
    ack("R8 address match", 1, 8'hAE, 0, 0, 0);
    eoi_pulse("R1 held high no retrigger", 0, 0);
    idle("R1 held high no retrigger", 0);
    @(negedge clk); req[6] = 1'b0; push("R1 drop", 0, 0, 0, 0, 0);
    raise("R1 new edge", 6, 0);
    idle("R1 new edge irq", 1);
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      checks++;
      if (scb.size() != 0) begin
        errors++;
        $display("FAIL scoreboard actual=%0d expected=0 pending", scb.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule